// File: doc/BRIEF.md
# SDRAM Start-Up Command Sequencer

This block sits on the controller side of an SDRAM interface and owns the command, address, clock-enable and mask pins from reset until the memory is ready for normal traffic. After reset it keeps the bus quiet with clock enable high and every data mask high. It waits out a long stabilization interval, closes every bank with a single precharge-all, issues a fixed number of auto-refresh commands spaced by the refresh cycle time, and loads the mode register from a mode word on its input.

The mode word is copied onto the address pins during the mode-register load. The column-access latency field of that word is captured at the same moment and reported as the effective read latency. One cycle is added to that latency when the memory is reached through a registered (latched) command path. A done flag rises once the mode-register recovery time has passed, and it stays up until the next reset. All delays and the refresh count are parameters given in clock cycles. Each delay must be at least 2, and the refresh count must be at least 8.

Cycle numbers below count rising clock edges after reset is released. Cycle 0 is the interval between the release of reset and the first edge. P = T_STAB + 1 and M = P + T_RP + N_REF * T_RFC.

Top module: `sdram_init_seq`

## Requirements
- R1: While reset is low, and in cycle 0, the pins show NOP (cs_n,ras_n,cas_n,we_n = 0,1,1,1), address 0, bank 0, cke_o high, dqm_o all ones, init_done_o low and cas_lat_o 0.
- R2: The first command other than NOP is a precharge-all in cycle P: pins 0,0,1,0, address bit 10 high and every other address and bank bit low.
- R3: Exactly N_REF auto-refresh commands follow (pins 0,0,0,1, address and bank 0). The first comes T_RP cycles after the precharge-all, and each later one comes T_RFC cycles after the one before.
- R4: A mode-register load (pins 0,0,0,0, bank 0) appears in cycle M, T_RFC cycles after the last refresh. Its address equals the mode_i value sampled at the preceding clock edge.
- R6: Every cycle that carries none of the commands in R2 to R4 shows NOP, so no two commands are ever back to back.
- R7: cke_o is high in every cycle. dqm_o is all ones exactly while init_done_o is low, and it is all zeros once init_done_o is high.
- R8: init_done_o rises in cycle M + T_RSC and then stays high with NOP on the pins until reset.
- R9: From cycle M on, cas_lat_o equals the value of mode bits 6..4 captured with the mode-register load, plus 1 when REG_LATCH is set (010 gives 2, 011 gives 3, before that addition).
- R10: Asserting reset in the middle of the sequence returns every output to its R1 value at once. After release, the whole sequence restarts from cycle 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; all activity on the rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| mode_i | input | ADDR_W | Mode word loaded into the memory's mode register |
| cs_n_o | output | 1 | Chip select, active low |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write enable, active low |
| addr_o | output | ADDR_W | Address pins |
| ba_o | output | BA_W | Bank address pins |
| cke_o | output | 1 | Clock enable |
| dqm_o | output | DQM_W | Data mask pins |
| cas_lat_o | output | 4 | Effective read latency captured at the mode-register load |
| init_done_o | output | 1 | Start-up sequence complete |

## Verification
The properties rely on three conditions about the inputs and parameters. Every delay parameter is at least 2. N_REF is the exact number of refreshes to be counted. mode_i is only compared against its value one edge before the mode-register load, so changes to it outside that edge are harmless. The bench keeps within these conditions: it uses a small legal configuration and changes the mode word only while reset is held. Each run is then swept cycle by cycle against a timeline computed from the parameters. Different mode words exercise the latency capture, and one run is cut short by reset to exercise the restart.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

  typedef enum logic [2:0] {
    ST_STAB,
    ST_PALL,
    ST_WAIT_RP,
    ST_AREF,
    ST_WAIT_RFC,
    ST_LMR,
    ST_WAIT_RSC,
    ST_DONE
  } init_state_e;

  typedef enum logic [1:0] {
    OP_NOP,
    OP_PALL,
    OP_AREF,
    OP_LMR
  } init_op_e;

  typedef struct packed {
    logic cs_n;
    logic ras_n;
    logic cas_n;
    logic we_n;
  } cmd_pins_t;

  function automatic cmd_pins_t op_to_pins(init_op_e op);
    cmd_pins_t p;
    unique case (op)
      OP_PALL: p = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b0};
      OP_AREF: p = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1};
      OP_LMR:  p = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b0};
      default: p = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
    endcase
    return p;
  endfunction

endpackage

// File: rtl/sdram_init_dctr.sv
module sdram_init_dctr #(
  parameter int W       = 8,
  parameter int RST_VAL = 0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         dec_i,
  output logic         zero_o
);

  localparam logic [W-1:0] ONE  = W'(1);
  localparam logic [W-1:0] RSTV = W'(RST_VAL);

  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_en = load_i | (dec_i & (cnt_q != '0));
    cnt_d  = load_i ? load_val_i : (cnt_q - ONE);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= RSTV;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/sdram_init_fsm.sv
module sdram_init_fsm
  import sdram_init_pkg::*;
#(
  parameter int T_STAB = 26600,
  parameter int T_RP   = 3,
  parameter int T_RFC  = 9,
  parameter int T_RSC  = 2,
  parameter int N_REF  = 8
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  output init_op_e op_o,
  output logic     capture_o,
  output logic     done_o
);

  localparam int TSUM = T_STAB + T_RP + T_RFC + T_RSC;
  localparam int DW   = $clog2(TSUM + 1);
  localparam int RW   = $clog2(N_REF + 1);

  localparam logic [DW-1:0] LD_RP  = DW'(T_RP - 2);
  localparam logic [DW-1:0] LD_RFC = DW'(T_RFC - 2);
  localparam logic [DW-1:0] LD_RSC = DW'(T_RSC - 2);
  localparam logic [RW-1:0] LD_REF = RW'(N_REF - 1);

  init_state_e state_q, state_d;

  logic          dly_load, dly_zero;
  logic [DW-1:0] dly_val;
  logic          ref_load, ref_dec, ref_zero;

  sdram_init_dctr #(
    .W       (DW),
    .RST_VAL (T_STAB - 1)
  ) u_dly (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (dly_load),
    .load_val_i (dly_val),
    .dec_i      (1'b1),
    .zero_o     (dly_zero)
  );

  sdram_init_dctr #(
    .W       (RW),
    .RST_VAL (N_REF - 1)
  ) u_refs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (ref_load),
    .load_val_i (LD_REF),
    .dec_i      (ref_dec),
    .zero_o     (ref_zero)
  );

  always_comb begin
    state_d  = state_q;
    dly_load = 1'b0;
    dly_val  = '0;
    ref_load = 1'b0;
    ref_dec  = 1'b0;
    unique case (state_q)
      ST_STAB:     if (dly_zero) state_d = ST_PALL;
      ST_PALL: begin
        dly_load = 1'b1;
        dly_val  = LD_RP;
        ref_load = 1'b1;
        state_d  = ST_WAIT_RP;
      end
      ST_WAIT_RP:  if (dly_zero) state_d = ST_AREF;
      ST_AREF: begin
        dly_load = 1'b1;
        dly_val  = LD_RFC;
        state_d  = ST_WAIT_RFC;
      end
      ST_WAIT_RFC: begin
        if (dly_zero) begin
          if (ref_zero) begin
            state_d = ST_LMR;
          end else begin
            ref_dec = 1'b1;
            state_d = ST_AREF;
          end
        end
      end
      ST_LMR: begin
        dly_load = 1'b1;
        dly_val  = LD_RSC;
        state_d  = ST_WAIT_RSC;
      end
      ST_WAIT_RSC: if (dly_zero) state_d = ST_DONE;
      default:     state_d = ST_DONE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_STAB;
    end else begin
      state_q <= state_d;
    end
  end

  always_comb begin
    unique case (state_q)
      ST_PALL: op_o = OP_PALL;
      ST_AREF: op_o = OP_AREF;
      ST_LMR:  op_o = OP_LMR;
      default: op_o = OP_NOP;
    endcase
  end

  assign capture_o = (state_q == ST_LMR);
  assign done_o    = (state_q == ST_DONE);

endmodule

// File: rtl/sdram_init_drive.sv
module sdram_init_drive
  import sdram_init_pkg::*;
#(
  parameter int   ADDR_W    = 13,
  parameter int   BA_W      = 2,
  parameter int   DQM_W     = 8,
  parameter int   AP_BIT    = 10,
  parameter int   CL_LSB    = 4,
  parameter logic REG_LATCH = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  init_op_e          op_i,
  input  logic              capture_i,
  input  logic              done_i,
  input  logic [ADDR_W-1:0] mode_i,
  output cmd_pins_t         pins_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [BA_W-1:0]   ba_o,
  output logic              cke_o,
  output logic [DQM_W-1:0]  dqm_o,
  output logic [3:0]        cas_lat_o,
  output logic              done_o
);

  localparam logic [ADDR_W-1:0] AP_MASK = ADDR_W'(1) << AP_BIT;

  cmd_pins_t         pins_d;
  logic [ADDR_W-1:0] addr_d;
  logic [3:0]        lat_d;

  always_comb begin
    pins_d = op_to_pins(op_i);
    unique case (op_i)
      OP_PALL: addr_d = AP_MASK;
      OP_LMR:  addr_d = mode_i;
      default: addr_d = '0;
    endcase
    lat_d = {1'b0, mode_i[CL_LSB+2:CL_LSB]} + {3'b000, REG_LATCH};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pins_o <= op_to_pins(OP_NOP);
      addr_o <= '0;
      ba_o   <= '0;
      cke_o  <= 1'b1;
      dqm_o  <= '1;
      done_o <= 1'b0;
    end else begin
      pins_o <= pins_d;
      addr_o <= addr_d;
      ba_o   <= '0;
      cke_o  <= 1'b1;
      dqm_o  <= done_i ? '0 : '1;
      done_o <= done_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cas_lat_o <= '0;
    end else if (capture_i) begin
      cas_lat_o <= lat_d;
    end
  end

endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
  import sdram_init_pkg::*;
#(
  parameter int   T_STAB    = 26600,
  parameter int   T_RP      = 3,
  parameter int   T_RFC     = 9,
  parameter int   T_RSC     = 2,
  parameter int   N_REF     = 8,
  parameter int   ADDR_W    = 13,
  parameter int   BA_W      = 2,
  parameter int   DQM_W     = 8,
  parameter logic REG_LATCH = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] mode_i,
  output logic              cs_n_o,
  output logic              ras_n_o,
  output logic              cas_n_o,
  output logic              we_n_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [BA_W-1:0]   ba_o,
  output logic              cke_o,
  output logic [DQM_W-1:0]  dqm_o,
  output logic [3:0]        cas_lat_o,
  output logic              init_done_o
);

  localparam int AP_BIT = 10;
  localparam int CL_LSB = 4;

  init_op_e  op;
  logic      capture, done_st;
  cmd_pins_t pins;

  sdram_init_fsm #(
    .T_STAB (T_STAB),
    .T_RP   (T_RP),
    .T_RFC  (T_RFC),
    .T_RSC  (T_RSC),
    .N_REF  (N_REF)
  ) u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .op_o      (op),
    .capture_o (capture),
    .done_o    (done_st)
  );

  sdram_init_drive #(
    .ADDR_W    (ADDR_W),
    .BA_W      (BA_W),
    .DQM_W     (DQM_W),
    .AP_BIT    (AP_BIT),
    .CL_LSB    (CL_LSB),
    .REG_LATCH (REG_LATCH)
  ) u_drive (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .op_i      (op),
    .capture_i (capture),
    .done_i    (done_st),
    .mode_i    (mode_i),
    .pins_o    (pins),
    .addr_o    (addr_o),
    .ba_o      (ba_o),
    .cke_o     (cke_o),
    .dqm_o     (dqm_o),
    .cas_lat_o (cas_lat_o),
    .done_o    (init_done_o)
  );

  assign cs_n_o  = pins.cs_n;
  assign ras_n_o = pins.ras_n;
  assign cas_n_o = pins.cas_n;
  assign we_n_o  = pins.we_n;

endmodule

// File: rtl/sdram_init_chk.sv
module sdram_init_chk #(
  parameter int   N_REF     = 8,
  parameter int   ADDR_W    = 13,
  parameter int   BA_W      = 2,
  parameter int   DQM_W     = 8,
  parameter logic REG_LATCH = 1'b0
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] mode_i,
  input logic              cs_n_o,
  input logic              ras_n_o,
  input logic              cas_n_o,
  input logic              we_n_o,
  input logic [ADDR_W-1:0] addr_o,
  input logic [BA_W-1:0]   ba_o,
  input logic              cke_o,
  input logic [DQM_W-1:0]  dqm_o,
  input logic [3:0]        cas_lat_o,
  input logic              init_done_o
);

  localparam int CW = $clog2(N_REF + 2);

  logic [3:0] pins;
  logic       is_nop, is_pall, is_aref, is_lmr;
  logic [CW-1:0] refs_seen;

  assign pins    = {cs_n_o, ras_n_o, cas_n_o, we_n_o};
  assign is_nop  = (pins == 4'b0111);
  assign is_pall = (pins == 4'b0010);
  assign is_aref = (pins == 4'b0001);
  assign is_lmr  = (pins == 4'b0000);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      refs_seen <= '0;
    end else if (is_aref && (refs_seen != CW'(N_REF + 1))) begin
      refs_seen <= refs_seen + CW'(1);
    end
  end

  // R2
  pall_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_pall |-> (addr_o[10] && ($countones(addr_o) == 1) && (ba_o == '0)));

  // R3
  ref_total_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_lmr |-> (refs_seen == CW'(N_REF)));

  // R4
  lmr_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_lmr |-> ((addr_o == $past(mode_i)) && (ba_o == '0)));

  // R6
  cmd_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !is_nop |=> is_nop);

  // R7
  cke_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cke_o);

  // R7
  dqm_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_done_o ? (dqm_o == '0) : (dqm_o == '1));

  // R8
  done_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_done_o |=> init_done_o);

  // R8
  quiet_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_done_o |-> is_nop);

  // R9
  cas_lat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_lmr |-> (cas_lat_o == ({1'b0, $past(mode_i[6:4])} + {3'b000, REG_LATCH})));

endmodule

bind sdram_init_seq sdram_init_chk #(
  .N_REF     (N_REF),
  .ADDR_W    (ADDR_W),
  .BA_W      (BA_W),
  .DQM_W     (DQM_W),
  .REG_LATCH (REG_LATCH)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .mode_i      (mode_i),
  .cs_n_o      (cs_n_o),
  .ras_n_o     (ras_n_o),
  .cas_n_o     (cas_n_o),
  .we_n_o      (we_n_o),
  .addr_o      (addr_o),
  .ba_o        (ba_o),
  .cke_o       (cke_o),
  .dqm_o       (dqm_o),
  .cas_lat_o   (cas_lat_o),
  .init_done_o (init_done_o)
);

// File: tb/sim_sdram_init_seq.sv
module sim_sdram_init_seq;

  localparam int   CLK_PERIOD = 10;
  localparam int   T_STAB     = 20;
  localparam int   T_RP       = 3;
  localparam int   T_RFC      = 5;
  localparam int   T_RSC      = 2;
  localparam int   N_REF      = 8;
  localparam int   ADDR_W     = 13;
  localparam int   BA_W       = 2;
  localparam int   DQM_W      = 8;
  localparam logic REG_LATCH  = 1'b1;

  localparam int P_CYC = T_STAB + 1;
  localparam int R_CYC = P_CYC + T_RP;
  localparam int M_CYC = R_CYC + N_REF * T_RFC;
  localparam int D_CYC = M_CYC + T_RSC;

  logic              clk;
  logic              rst_n;
  logic [ADDR_W-1:0] mode;
  logic              cs_n, ras_n, cas_n, we_n;
  logic [ADDR_W-1:0] addr;
  logic [BA_W-1:0]   ba;
  logic              cke;
  logic [DQM_W-1:0]  dqm;
  logic [3:0]        cas_lat;
  logic              done;

  int n_cmp;
  int n_bad;

  sdram_init_seq #(
    .T_STAB    (T_STAB),
    .T_RP      (T_RP),
    .T_RFC     (T_RFC),
    .T_RSC     (T_RSC),
    .N_REF     (N_REF),
    .ADDR_W    (ADDR_W),
    .BA_W      (BA_W),
    .DQM_W     (DQM_W),
    .REG_LATCH (REG_LATCH)
  ) u0 (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .mode_i      (mode),
    .cs_n_o      (cs_n),
    .ras_n_o     (ras_n),
    .cas_n_o     (cas_n),
    .we_n_o      (we_n),
    .addr_o      (addr),
    .ba_o        (ba),
    .cke_o       (cke),
    .dqm_o       (dqm),
    .cas_lat_o   (cas_lat),
    .init_done_o (done)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic chk(input string req, input string what, input int k,
                     input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s cycle %0d: actual %0h expected %0h", req, what, k, act, exp);
    end
  endtask

  // 0 NOP, 1 precharge-all, 2 refresh, 3 mode load
  function automatic int exp_op(input int k);
    if (k == P_CYC) return 1;
    if (k >= R_CYC && k < M_CYC && ((k - R_CYC) % T_RFC) == 0) return 2;
    if (k == M_CYC) return 3;
    return 0;
  endfunction

  task automatic check_cycle(input int k, input logic [ADDR_W-1:0] m, input string rst_tag);
    int    op;
    string tag;
    logic [3:0]        e_pins;
    logic [ADDR_W-1:0] e_addr;
    logic              e_done;
    logic [3:0]        e_lat;
    op = exp_op(k);
    case (op)
      1: begin tag = "R2"; e_pins = 4'b0010; e_addr = ADDR_W'(1) << 10; end
      2: begin tag = "R3"; e_pins = 4'b0001; e_addr = '0; end
      3: begin tag = "R4"; e_pins = 4'b0000; e_addr = m; end
      default: begin
        tag    = (k == 0) ? rst_tag : ((k >= D_CYC) ? "R8" : "R6");
        e_pins = 4'b0111;
        e_addr = '0;
      end
    endcase
    e_done = (k >= D_CYC);
    e_lat  = (k >= M_CYC) ? 4'(((int'(m) >> 4) & 7) + int'(REG_LATCH)) : 4'd0;
    chk(tag, "pins", k, 64'({cs_n, ras_n, cas_n, we_n}), 64'(e_pins));
    chk(tag, "addr", k, 64'(addr), 64'(e_addr));
    chk(tag, "bank", k, 64'(ba), 64'd0);
    chk((k == 0) ? rst_tag : "R7", "cke", k, 64'(cke), 64'd1);
    chk((k == 0) ? rst_tag : "R7", "dqm", k, 64'(dqm), e_done ? 64'd0 : 64'hFF);
    chk((k == 0) ? rst_tag : "R8", "done", k, 64'(done), 64'(e_done));
    chk((k == 0) ? rst_tag : "R9", "cas_lat", k, 64'(cas_lat), 64'(e_lat));
  endtask

  task automatic run_seq(input logic [ADDR_W-1:0] m, input int last_k, input string rst_tag);
    mode  = m;
    rst_n = 1'b0;
    @(negedge clk);
    // R1 / R10: values while reset is held
    chk(rst_tag, "pins in reset", -1, 64'({cs_n, ras_n, cas_n, we_n}), 64'h7);
    chk(rst_tag, "addr in reset", -1, 64'(addr), 64'd0);
    chk(rst_tag, "cke in reset", -1, 64'(cke), 64'd1);
    chk(rst_tag, "dqm in reset", -1, 64'(dqm), 64'hFF);
    chk(rst_tag, "done in reset", -1, 64'(done), 64'd0);
    chk(rst_tag, "cas_lat in reset", -1, 64'(cas_lat), 64'd0);
    rst_n = 1'b1;
    for (int k = 0; k <= last_k; k++) begin
      if (k > 0) @(negedge clk);
      check_cycle(k, m, rst_tag);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL R8 watchdog: actual running expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    n_cmp = 0;
    n_bad = 0;
    rst_n = 1'b0;
    mode  = '0;
    repeat (3) @(negedge clk);
    // R1 full run, latency code 010 -> 2 (+1 registered path)
    run_seq(13'h0020, D_CYC + 12, "R1");
    // R10 run cut short in the middle of the refresh phase
    run_seq(13'h0037, R_CYC + 2 * T_RFC + 1, "R1");
    // R10 restart, latency code 011, other mode bits set
    run_seq(13'h1A35, D_CYC + 8, "R10");
    // R9 latency code 101 with a wide mode word
    run_seq(13'h0F5A, D_CYC + 4, "R10");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule